// File: doc/BRIEF.md
# I2C Master Bus Condition and Byte Engine

This block is the bus-facing engine of a register-driven I2C master. Software writes a 4-bit control word that holds an enable bit, a two-bit command and a condition flag. A command either does nothing, creates a START or a repeated START, or creates a STOP on the open-drain SCL and SDA lines. A write to the data port makes the engine shift one byte out MSB first and then release SDA for the acknowledge slot. It samples the target's answer there and reports it.

A status word reports three things: a session-done bit for every completed command or byte, a no-acknowledge bit, and a command-busy bit that covers the generation of a bus condition. The line drive outputs are pull-low enables: 1 pulls the line low and 0 releases it. Every bus event is built from "steps". A step holds one SCL/SDA drive pair for `QTR` clock cycles. A byte takes nine bits of four steps each.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0 (both lines released), csr_rdata reads 0 and sts_rdata reads 0.
- R2: A control write of {flag=0, cmd=1, en=1} (value 0x3) while idle starts a START. The lines take three steps of QTR cycles each, beginning at the clock edge that samples the write. As (scl_oe,sda_oe) the steps are (0,0), (0,1), (1,1).
- R3: A control write of {flag=1, cmd=1, en=1} (value 0xB) starts a repeated START. It takes four steps: (1,0), (0,0), (0,1), (1,1).
- R4: A control write with cmd=2 and en=1 (value 0x5) starts a STOP. It takes three steps: (1,1), (0,1), (0,0).
- R5: A data write while idle and enabled sends the byte in 9 bits of 4 steps each. scl_oe is 1,0,0,1 across the four steps. sda_oe is the inverse of the data bit, MSB first, for bits 0 to 7, and 0 for bit 8.
- R6: The engine samples sda_in on the edge that ends the third step of bit 8. When the byte completes, control bit 3 holds the sampled level (1 = NAK, 0 = ACK), and a NAK also sets status bit 0.
- R7: Status bit 3 (session done) is set on the edge that ends the last step of every command or byte.
- R8: Status bit 7 (busy) is 1 from the accepting edge of a START, repeated START or STOP until its completing edge. It stays 0 during byte transfers.
- R9: Status bits 0 and 3 are cleared by writing 1 to them through the status write port. Writing 0 leaves them unchanged.
- R10: A control write with cmd=0, cmd=3 or en=0 launches nothing: the lines hold and no done is reported.
- R11: Control and data writes made while a sequence runs are ignored. The register value is unchanged and nothing extra is launched.
- R12: A data write while en=0 launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Control word write strobe |
| csr_wdata | input | 4 | Control word: bit0 en, bits[2:1] cmd, bit3 flag |
| csr_rdata | output | 4 | Control word readback; bit3 holds ACK/NAK after a byte |
| dat_we | input | 1 | Data byte write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| sts_we | input | 1 | Status write strobe (write 1 to clear) |
| sts_wdata | input | 8 | Status clear mask |
| sts_rdata | output | 8 | Status: bit7 busy, bit3 done, bit0 NAK |
| scl_oe | output | 1 | SCL pull-low enable |
| sda_oe | output | 1 | SDA pull-low enable |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The line drive for step k of a sequence is due between edge E0+k*QTR and edge E0+(k+1)*QTR, where E0 is the edge that samples the write. The bench checks each step on the falling edge just after the step begins. Done, busy release, the NAK bit and the flag readback all change on edge E0+N*QTR, where N is the number of steps. The bench samples them on the following falling edge, and busy is checked at every step before that. Writes that must be ignored are followed by a twelve-cycle hold of the lines and the status, or by a readback of the control word after the running sequence has ended.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_STOP    = 2'd2,
    OP_BYTE    = 2'd3
  } op_e;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_COND = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;

  localparam int STS_NAK  = 0;
  localparam int STS_DONE = 3;
  localparam int STS_BUSY = 7;

  // Index of the final step of one unit (a whole condition, or one byte bit)
  function automatic logic [1:0] last_step_of(op_e op);
    case (op)
      OP_RESTART: return 2'd3;
      OP_BYTE:    return 2'd3;
      default:    return 2'd2;
    endcase
  endfunction

  // Released-line pattern {scl_rel, sda_rel} for a step
  function automatic logic [1:0] step_lines(op_e op, logic [1:0] step, logic val);
    case (op)
      OP_START: begin
        case (step)
          2'd0:    return 2'b11;
          2'd1:    return 2'b10;
          default: return 2'b00;
        endcase
      end
      OP_RESTART: begin
        case (step)
          2'd0:    return 2'b01;
          2'd1:    return 2'b11;
          2'd2:    return 2'b10;
          default: return 2'b00;
        endcase
      end
      OP_STOP: begin
        case (step)
          2'd0:    return 2'b00;
          2'd1:    return 2'b10;
          default: return 2'b11;
        endcase
      end
      default: return {(step == 2'd1) || (step == 2'd2), val};
    endcase
  endfunction

  function automatic logic is_launch_cmd(logic [3:0] w);
    return w[0] && ((w[2:1] == CMD_COND) || (w[2:1] == CMD_STOP));
  endfunction

  function automatic op_e op_of_cmd(logic [3:0] w);
    if (w[2:1] == CMD_COND) return w[3] ? OP_RESTART : OP_START;
    return OP_STOP;
  endfunction

endpackage

// File: rtl/i2c_qtimer.sv
module i2c_qtimer #(
  parameter int QTR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] CMAX = CW'(QTR - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2c_step_seq.sv
module i2c_step_seq
  import i2c_eng_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  op_e              launch_op,
  input  logic [NBITS-1:0] launch_byte,
  input  logic             tick,
  input  logic             sda_in,
  output logic             run,
  output op_e              op_q,
  output logic             fin,
  output logic             fin_nak,
  output logic             scl_rel,
  output logic             sda_rel
);
  localparam int BW = $clog2(NBITS + 1);
  localparam logic [BW-1:0] ACK_BIT = BW'(NBITS);

  logic [1:0]       step;
  logic [BW-1:0]    bitn;
  logic [NBITS-1:0] shreg;
  logic             ack_s;
  logic             last_step, last_bit, cur_val, nxt_val;

  assign cur_val   = (bitn == ACK_BIT) ? 1'b1 : shreg[NBITS-1];
  assign nxt_val   = (bitn == ACK_BIT - BW'(1)) ? 1'b1 : shreg[NBITS-2];
  assign last_step = (step == last_step_of(op_q));
  assign last_bit  = (op_q != OP_BYTE) || (bitn == ACK_BIT);
  assign fin       = run && tick && last_step && last_bit;
  assign fin_nak   = (op_q == OP_BYTE) && ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      op_q    <= OP_START;
      step    <= '0;
      bitn    <= '0;
      shreg   <= '0;
      ack_s   <= 1'b0;
      scl_rel <= 1'b1;
      sda_rel <= 1'b1;
    end else if (!run) begin
      if (launch) begin
        run   <= 1'b1;
        op_q  <= launch_op;
        step  <= '0;
        bitn  <= '0;
        shreg <= launch_byte;
        ack_s <= 1'b0;
        {scl_rel, sda_rel} <= step_lines(launch_op, 2'd0, launch_byte[NBITS-1]);
      end
    end else if (tick) begin
      if ((op_q == OP_BYTE) && (bitn == ACK_BIT) && (step == 2'd2))
        ack_s <= sda_in;
      if (last_step && last_bit) begin
        run <= 1'b0;
      end else if (last_step) begin
        step  <= '0;
        bitn  <= bitn + BW'(1);
        shreg <= {shreg[NBITS-2:0], 1'b0};
        {scl_rel, sda_rel} <= step_lines(op_q, 2'd0, nxt_val);
      end else begin
        step <= step + 2'd1;
        {scl_rel, sda_rel} <= step_lines(op_q, step + 2'd1, cur_val);
      end
    end
  end
endmodule

// File: rtl/i2c_eng_regs.sv
module i2c_eng_regs
  import i2c_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_we,
  input  logic [3:0] csr_wdata,
  input  logic       dat_we,
  input  logic       sts_we,
  input  logic       clr_nak,
  input  logic       clr_done,
  input  logic       run,
  input  logic       fin,
  input  logic       fin_byte,
  input  logic       fin_nak,
  output logic [3:0] csr_q,
  output logic [7:0] sts_q,
  output logic       launch,
  output op_e        launch_op
);
  logic busy, done, nak, launch_cmd, launch_byte;

  assign launch_cmd  = csr_we && !run && is_launch_cmd(csr_wdata);
  assign launch_byte = dat_we && !run && !csr_we && csr_q[0];
  assign launch      = launch_cmd || launch_byte;
  assign launch_op   = launch_cmd ? op_of_cmd(csr_wdata) : OP_BYTE;

  always_comb begin
    sts_q           = '0;
    sts_q[STS_BUSY] = busy;
    sts_q[STS_DONE] = done;
    sts_q[STS_NAK]  = nak;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      nak   <= 1'b0;
    end else begin
      if (csr_we && !run)          csr_q    <= csr_wdata;
      else if (fin && fin_byte)    csr_q[3] <= fin_nak;

      if (launch_cmd)              busy <= 1'b1;
      else if (fin)                busy <= 1'b0;

      if (fin)                     done <= 1'b1;
      else if (sts_we && clr_done) done <= 1'b0;

      if (fin && fin_nak)          nak <= 1'b1;
      else if (sts_we && clr_nak)  nak <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_eng_pkg::*;
#(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_we,
  input  logic [3:0] csr_wdata,
  output logic [3:0] csr_rdata,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  input  logic       sts_we,
  input  logic [7:0] sts_wdata,
  output logic [7:0] sts_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic run_w, fin_w, fin_nak_w, tick_w, launch_w, scl_rel_w, sda_rel_w;
  logic is_cond_w, clr_mask_unused;
  op_e  op_w, launch_op_w;

  assign clr_mask_unused = ^{sts_wdata[7:4], sts_wdata[2:1]};
  assign is_cond_w       = (op_w != OP_BYTE);

  i2c_qtimer #(.QTR(QTR)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w)
  );

  i2c_eng_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .dat_we(dat_we),
    .sts_we(sts_we), .clr_nak(sts_wdata[STS_NAK]), .clr_done(sts_wdata[STS_DONE]),
    .run(run_w), .fin(fin_w), .fin_byte(!is_cond_w), .fin_nak(fin_nak_w),
    .csr_q(csr_rdata), .sts_q(sts_rdata),
    .launch(launch_w), .launch_op(launch_op_w)
  );

  i2c_step_seq #(.NBITS(8)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch_w), .launch_op(launch_op_w), .launch_byte(dat_wdata),
    .tick(tick_w), .sda_in(sda_in),
    .run(run_w), .op_q(op_w), .fin(fin_w), .fin_nak(fin_nak_w),
    .scl_rel(scl_rel_w), .sda_rel(sda_rel_w)
  );

  assign scl_oe = !scl_rel_w;
  assign sda_oe = !sda_rel_w;
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic fin,
  input logic fin_nak,
  input logic is_cond,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done,
  input logic nak,
  input logic sts_we,
  input logic clr_nak
);
  // R8: busy never outlives the running sequence
  a_r8_busy_within_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run);

  // R7: done only rises on a completing edge
  a_r7_done_from_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));

  // R10: lines hold while idle
  a_r10_idle_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> ($stable(scl_oe) && $stable(sda_oe)));

  // R5: during a byte, SDA never moves while SCL stays released
  a_r5_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> is_cond);

  // R6: NAK status only rises from a finishing byte that saw NAK
  a_r6_nak_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak) |-> $past(fin && fin_nak));

  // R9: a write of 1 clears the NAK bit when no new NAK arrives
  a_r9_nak_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && clr_nak && !(fin && fin_nak)) |=> !nak);
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_w), .fin(fin_w), .fin_nak(fin_nak_w),
  .is_cond(is_cond_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(sts_rdata[7]), .done(sts_rdata[3]), .nak(sts_rdata[0]),
  .sts_we(sts_we), .clr_nak(sts_wdata[0])
);

// File: tb/sim_i2c_cmd_engine.sv
module sim_i2c_cmd_engine;
  localparam int Q = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0, dat_we = 1'b0, sts_we = 1'b0;
  logic [3:0] csr_wdata = '0;
  logic [7:0] dat_wdata = '0, sts_wdata = '0;
  logic [3:0] csr_rdata;
  logic [7:0] sts_rdata;
  logic scl_oe, sda_oe, sda_in;
  logic tgt_pull = 1'b0;
  int   n_chk = 0, n_err = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  assign sda_in = !(sda_oe || tgt_pull);

  i2c_cmd_engine #(.QTR(Q)) u0 (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // ops: 0 start, 1 restart, 2 stop, 3 byte; result {scl_oe, sda_oe}
  function automatic logic [1:0] exp_oe(int op, int k, logic [7:0] b);
    int bi, qd;
    logic v;
    case (op)
      0: return (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
      1: return (k == 0) ? 2'b10 : (k == 1) ? 2'b00 : (k == 2) ? 2'b01 : 2'b11;
      2: return (k == 0) ? 2'b11 : (k == 1) ? 2'b01 : 2'b00;
      default: begin
        bi = k / 4;
        qd = k % 4;
        v  = (bi < 8) ? b[7 - bi] : 1'b1;
        return {!(qd == 1 || qd == 2), !v};
      end
    endcase
  endfunction

  task automatic wr_csr(input logic [3:0] v);
    @(negedge clk); csr_we = 1'b1; csr_wdata = v;
    @(posedge clk); #1 csr_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(posedge clk); #1 dat_we = 1'b0;
  endtask

  task automatic clr_sts(input logic [7:0] m);
    @(negedge clk); sts_we = 1'b1; sts_wdata = m;
    @(posedge clk); #1 sts_we = 1'b0;
  endtask

  task automatic hold_check(input string req);
    logic [1:0] l0;
    logic moved = 1'b0, dn = 1'b0;
    @(negedge clk);
    l0 = {scl_oe, sda_oe};
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if ({scl_oe, sda_oe} != l0) moved = 1'b1;
      if (sts_rdata[3]) dn = 1'b1;
    end
    chk({req, " lines hold"}, int'(moved), 0);
    chk({req, " no done"}, int'(dn), 0);
  endtask

  task automatic run_seq(input int op, input logic [7:0] b, input logic ack);
    int n;
    string tag;
    n   = (op == 3) ? 36 : (op == 1) ? 4 : 3;
    tag = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
    tgt_pull = (op == 3) && ack;
    if (op == 0)      wr_csr(4'h3);
    else if (op == 1) wr_csr(4'hB);
    else if (op == 2) wr_csr(4'h5);
    else              wr_dat(b);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      chk({tag, " lines"}, int'({scl_oe, sda_oe}), int'(exp_oe(op, k, b)));
      chk("R8 busy during run", int'(sts_rdata[7]), int'(op != 3));
      repeat (Q) @(negedge clk);
    end
    chk("R7 done set", int'(sts_rdata[3]), 1);
    chk("R8 busy cleared", int'(sts_rdata[7]), 0);
    if (op == 3) begin
      chk("R6 nak status", int'(sts_rdata[0]), int'(!ack));
      chk("R6 flag readback", int'(csr_rdata[3]), int'(!ack));
    end
    tgt_pull = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    chk("R1 scl released", int'(scl_oe), 0);
    chk("R1 sda released", int'(sda_oe), 0);
    chk("R1 csr", int'(csr_rdata), 0);
    chk("R1 sts", int'(sts_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sts after release", int'(sts_rdata), 0);

    wr_csr(4'h1);
    hold_check("R10 cmd0");

    run_seq(0, 8'h00, 1'b0);
    clr_sts(8'h08);
    @(negedge clk);
    chk("R9 done cleared", int'(sts_rdata), 0);

    wr_csr(4'h0);
    wr_dat(8'h55);
    hold_check("R12 disabled data");
    wr_csr(4'h1);

    for (int i = 0; i < 12; i++) begin
      b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 53) ^ 8'hA5);
      run_seq(3, b, i[0]);
      if (i == 2) begin
        clr_sts(8'h00);
        @(negedge clk);
        chk("R9 zero write keeps", int'(sts_rdata), 'h09);
        clr_sts(8'h01);
        @(negedge clk);
        chk("R9 nak only cleared", int'(sts_rdata), 'h08);
      end
      clr_sts(8'h09);
      @(negedge clk);
      chk("R9 cleared", int'(sts_rdata), 0);
    end

    run_seq(1, 8'h00, 1'b0);
    wr_csr(4'h1);
    clr_sts(8'h08);

    // R11: writes during a running byte are ignored
    tgt_pull = 1'b1;
    wr_dat(8'hC3);
    repeat (10) @(negedge clk);
    csr_we = 1'b1; csr_wdata = 4'h5; dat_we = 1'b1; dat_wdata = 8'h00;
    @(negedge clk);
    csr_we = 1'b0; dat_we = 1'b0;
    repeat (40 * Q) @(negedge clk);
    tgt_pull = 1'b0;
    chk("R11 csr unchanged", int'(csr_rdata), 'h1);
    chk("R11 lines after byte", int'({scl_oe, sda_oe}), 'b10);
    clr_sts(8'h09);
    hold_check("R11 no extra launch");

    wr_csr(4'h7);
    hold_check("R10 cmd3");
    wr_csr(4'h1);

    run_seq(2, 8'h00, 1'b0);
    chk("R4 final csr", int'(csr_rdata), 'h5);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule